// File: doc/BRIEF.md
# IDE Interrupt Status and Gating

This block gathers the interrupt request lines of up to three IDE ports and presents them to software and to the host. Each line is brought into the clock domain through a two-flop synchroniser. Its level can be read in bit 7 of a byte-wide status register. Each status register answers anywhere inside its own 64-byte window of the register page.

Forwarding of the combined request to the host is held off after reset. It starts only when software writes into the enable window. That enable is sticky: software can neither clear it nor read it back, and only reset removes it. A drive that raises its request line while it powers up therefore cannot stall the host before the driver is ready.

A two-port build keeps the third status window. That window always reads as "no interrupt", and the third request input is ignored. Software written for three ports therefore runs unchanged. Because writing any value sets the enable, the block has no write-data input.

Top module: `ide_irq_gate`

## Requirements
- R1: A read anywhere in 0xF00–0xF3F returns the synchronised level of `irq_i[0]` in bit 7.
- R2: A read in 0xF40–0xF7F returns the level of `irq_i[1]` in bit 7. A read in 0xF80–0xFBF returns the level of `irq_i[2]` in bit 7.
- R3: A write strobe to any address in 0xFC0–0xFFF sets the enable. Nothing except reset clears it.
- R4: While the enable is clear, `host_irq_o` stays 0 whatever the request inputs do.
- R5: With the enable set, `host_irq_o` is the OR of the request inputs. A change on `irq_i` reaches `host_irq_o` on the third rising clock edge after it, and not before.
- R6: A read in 0xFC0–0xFFF returns 0x00, whether or not the enable is set.
- R7: Bits 6 to 0 of every read value are 0.
- R8: With `NUM_PORTS` = 2, a read in 0xF80–0xFBF returns 0x00, and `irq_i[2]` has no effect on `host_irq_o`.
- R9: `rdata_o` carries the value for the read whose `rd_i` was sampled on the previous rising edge. It is 0x00 in every cycle that follows no read.
- R10: Reads outside 0xF00–0xFFF return 0x00. Writes outside 0xFC0–0xFFF leave the enable clear.
- R11: During and straight after reset, `host_irq_o` and `rdata_o` are 0 and the enable is clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| addr_i | input | 12 | Byte address within the board register space |
| rd_i | input | 1 | Read strobe, one cycle per access |
| wr_i | input | 1 | Write strobe, one cycle per access |
| irq_i | input | 3 | Asynchronous IDE port request lines, bit n for port n |
| rdata_o | output | 8 | Read data, valid the cycle after `rd_i` |
| host_irq_o | output | 1 | Gated interrupt request to the host |

## Verification
The hard case is a request that is already high while the enable is still clear. To reach it, the bench raises the request lines and holds them, then sends write strobes only to addresses outside the enable window. It then confirms that the host line stays low while the status reads show the request. Only after that does it write into the enable window at a random mirror address. From then on, random reads, writes and request changes run against a reference model. A two-port instance receives the same stimulus in parallel, so the masking of the third port is checked on every operation.

// File: rtl/ide_irq_pkg.sv
package ide_irq_pkg;
  localparam int ADDR_W  = 12;
  localparam int DATA_W  = 8;
  localparam int MAX_PORTS = 3;
  localparam logic [3:0] REG_PAGE = 4'hF;

  typedef enum logic [1:0] {
    WIN_P0 = 2'd0,
    WIN_P1 = 2'd1,
    WIN_P2 = 2'd2,
    WIN_EN = 2'd3
  } win_e;
endpackage

// File: rtl/ide_irq_sync.sv
module ide_irq_sync #(
  parameter int WIDTH  = 3,
  parameter int STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] async_i,
  output logic [WIDTH-1:0] sync_o
);
  logic [WIDTH-1:0] stage_q [STAGES];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) stage_q[0] <= '0;
    else         stage_q[0] <= async_i;
  end

  for (genvar s = 1; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) stage_q[s] <= '0;
      else         stage_q[s] <= stage_q[s-1];
    end
  end

  assign sync_o = stage_q[STAGES-1];
endmodule

// File: rtl/ide_irq_regs.sv
module ide_irq_regs
  import ide_irq_pkg::*;
#(
  parameter int NUM_PORTS = 3
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [ADDR_W-1:0]    addr_i,
  input  logic                 rd_i,
  input  logic                 wr_i,
  input  logic [MAX_PORTS-1:0] irq_sync_i,
  output logic [DATA_W-1:0]    rdata_o,
  output logic                 en_o
);
  logic              page_hit;
  win_e              win;
  logic              lvl;
  logic [DATA_W-1:0] rd_val;
  logic [DATA_W-1:0] rdata_q;
  logic              en_q;

  assign page_hit = (addr_i[ADDR_W-1:8] == REG_PAGE);
  assign win      = win_e'(addr_i[7:6]);

  // low six address bits ignored: each register mirrors across its window
  always_comb begin
    unique case (win)
      WIN_P0:  lvl = irq_sync_i[0];
      WIN_P1:  lvl = irq_sync_i[1];
      WIN_P2:  lvl = irq_sync_i[2];
      default: lvl = 1'b0;
    endcase
    rd_val = {lvl, {(DATA_W-1){1'b0}}};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rdata_q <= '0;
    else         rdata_q <= (rd_i && page_hit) ? rd_val : '0;
  end

  // sticky: set by any write in the enable window, cleared by reset only
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                              en_q <= 1'b0;
    else if (wr_i && page_hit && win == WIN_EN) en_q <= 1'b1;
  end

  assign rdata_o = rdata_q;
  assign en_o    = en_q;

  // R3
  en_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_q |=> en_q);
  // R3
  en_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && addr_i >= 12'hFC0) |=> en_q);
  // R6
  en_unreadable_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_i && addr_i >= 12'hFC0) |=> (rdata_o == '0));
  // R7
  low_bits_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rdata_o[DATA_W-2:0] == '0);
  // R8
  p2_absent_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (NUM_PORTS < 3 && rd_i && addr_i[11:6] == 6'b1111_10) |=> (rdata_o == '0));
  // R9
  idle_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_i |=> (rdata_o == '0));
endmodule

// File: rtl/ide_irq_gate.sv
module ide_irq_gate
  import ide_irq_pkg::*;
#(
  parameter int NUM_PORTS   = 3,
  parameter int SYNC_STAGES = 2
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [ADDR_W-1:0]    addr_i,
  input  logic                 rd_i,
  input  logic                 wr_i,
  input  logic [MAX_PORTS-1:0] irq_i,
  output logic [DATA_W-1:0]    rdata_o,
  output logic                 host_irq_o
);
  logic [MAX_PORTS-1:0] irq_sync;
  logic [MAX_PORTS-1:0] irq_live;
  logic                 en;
  logic                 host_q;

  ide_irq_sync #(.WIDTH(MAX_PORTS), .STAGES(SYNC_STAGES)) u_sync (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .async_i (irq_i),
    .sync_o  (irq_sync)
  );

  // absent ports read as idle and never raise the host line
  for (genvar p = 0; p < MAX_PORTS; p++) begin : g_port
    if (p < NUM_PORTS) begin : g_on
      assign irq_live[p] = irq_sync[p];
    end else begin : g_off
      assign irq_live[p] = 1'b0;
    end
  end

  ide_irq_regs #(.NUM_PORTS(NUM_PORTS)) u_regs (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .addr_i     (addr_i),
    .rd_i       (rd_i),
    .wr_i       (wr_i),
    .irq_sync_i (irq_live),
    .rdata_o    (rdata_o),
    .en_o       (en)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) host_q <= 1'b0;
    else         host_q <= en & (|irq_live);
  end

  assign host_irq_o = host_q;

  // R4
  gate_closed_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en |=> !host_irq_o);
  // R5
  gate_open_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en && (|irq_sync[NUM_PORTS-1:0])) |=> host_irq_o);
  // R8
  p2_mask_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (NUM_PORTS < 3 && irq_sync[1:0] == 2'b00) |=> !host_irq_o);
endmodule

// File: tb/ide_irq_gate_bench.sv
module ide_irq_gate_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [11:0] addr = '0;
  logic        rd = 1'b0;
  logic        wr = 1'b0;
  logic [2:0]  irq = '0;
  logic [7:0]  rdata, rdata2;
  logic        host, host2;

  int n_chk = 0;
  int n_fail = 0;
  bit exp_en = 1'b0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  ide_irq_gate u_ide_irq_gate (
    .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .rd_i(rd), .wr_i(wr),
    .irq_i(irq), .rdata_o(rdata), .host_irq_o(host));

  ide_irq_gate #(.NUM_PORTS(2)) u_ide_irq_gate_2p (
    .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .rd_i(rd), .wr_i(wr),
    .irq_i(irq), .rdata_o(rdata2), .host_irq_o(host2));

  function automatic logic [7:0] exp_read(logic [11:0] a, logic [2:0] lv, int np);
    if (a[11:8] != 4'hF) return 8'h00;
    case (a[7:6])
      2'd0: return {lv[0], 7'b0};
      2'd1: return {lv[1], 7'b0};
      2'd2: return (np > 2) ? {lv[2], 7'b0} : 8'h00;
      default: return 8'h00;
    endcase
  endfunction

  function automatic logic exp_host(logic en, logic [2:0] lv, int np);
    return en && (np > 2 ? |lv : |lv[1:0]);
  endfunction

  task automatic check(string req, logic [7:0] act, logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic tick(int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic do_read(logic [11:0] a, string req);
    addr = a; rd = 1'b1;
    tick(1);
    rd = 1'b0;
    check(req, rdata, exp_read(a, irq, 3));
    check({req, " 2p"}, rdata2, exp_read(a, irq, 2));
    tick(1);
    check("R9 idle", rdata, 8'h00);
  endtask

  task automatic do_write(logic [11:0] a);
    addr = a; wr = 1'b1;
    tick(1);
    wr = 1'b0;
    if (a >= 12'hFC0) exp_en = 1'b1;
    tick(1);
    check("R3/R4/R10 host", {7'b0, host}, {7'b0, exp_host(exp_en, irq, 3)});
    check("R8 host 2p", {7'b0, host2}, {7'b0, exp_host(exp_en, irq, 2)});
  endtask

  task automatic set_irq(logic [2:0] v);
    irq = v;
    tick(4);
    check("R4/R5 host", {7'b0, host}, {7'b0, exp_host(exp_en, irq, 3)});
    check("R8 host 2p", {7'b0, host2}, {7'b0, exp_host(exp_en, irq, 2)});
  endtask

  initial begin
    void'($urandom(32'h1DE5));
    #1;
    check("R11 rdata", rdata, 8'h00);
    check("R11 host", {7'b0, host}, 8'h00);
    tick(3);
    rst_n = 1'b1;
    tick(1);
    check("R11 host after", {7'b0, host}, 8'h00);

    // disabled phase: requests pending, host must stay low
    set_irq(3'b111);
    check("R4 held", {7'b0, host}, 8'h00);
    do_read(12'hF00, "R1 base");
    do_read(12'hF3F, "R1 mirror");
    do_read(12'hF5A, "R2 p1");
    do_read(12'hFBF, "R2 p2");
    do_read(12'hFC0, "R6 before");
    do_read(12'h700, "R10 read");
    do_write(12'hF00);
    do_write(12'hEFF);
    do_write(12'h3C0);
    for (int i = 0; i < 60; i++) begin
      logic [11:0] a;
      a = 12'($urandom);
      if (a >= 12'hFC0) a = 12'hF80;
      if ($urandom % 2) do_write(a); else do_read(a, "R1/R2/R10 rnd");
    end

    // enable via a mirror address
    set_irq(3'b000);
    do_write(12'hFC0 | 12'($urandom % 64));
    // latency: change visible on the third edge
    irq = 3'b010;
    tick(2);
    check("R5 early", {7'b0, host}, 8'h00);
    tick(1);
    check("R5 edge3", {7'b0, host}, 8'h01);
    set_irq(3'b100);
    check("R8 p2 only", {7'b0, host2}, 8'h00);
    do_read(12'hF9C, "R8 read");
    do_read(12'hFFF, "R6 after");
    do_write(12'hFE3);

    for (int i = 0; i < 300; i++) begin
      logic [11:0] a;
      a = ($urandom % 4 != 0) ? (12'hF00 | 12'($urandom % 256)) : 12'($urandom);
      case ($urandom % 3)
        0: set_irq(3'($urandom));
        1: do_read(a, "R1/R2/R6/R7 rnd");
        default: do_write(a);
      endcase
    end
    set_irq(3'b000);
    check("R3 still set", {7'b0, u_ide_irq_gate.host_irq_o}, 8'h00);
    set_irq(3'b001);
    check("R3 sticky", {7'b0, host}, 8'h01);

    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    #800000;
    if (!done) begin
      done = 1'b1;
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule